// File: doc/BRIEF.md
# Frame Check Sequence Generator with Error Injection

This block sits in a byte-wide packet transmit path. Packets arrive as a byte stream with start and end flags. For each packet the block runs a cyclic redundancy check over every byte and, when appending is on, adds the inverted check value as trailer bytes after the last data byte. A configuration bit picks a 16-bit or a 32-bit polynomial. While the trailer is being sent, the block holds off its input with a ready signal.

For link testing, the block can flip exactly one bit of the trailer in chosen packets. The flipped position moves on by one with each errored packet. Errors come from one of two sources. In programmed mode, an arm pulse loads a count of errored packets and the number of clean packets between them. In manual mode, a single-cycle request pulse marks a packet for corruption.

Top module: `fcs_gen`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: A byte accepted (in_valid_i and in_ready_o high at a clock edge) appears on out_data_o with out_valid_o high one cycle later, with out_sop_o equal to its start flag.
- R3: With cfg_crc32_i high, the check uses x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. The register is preset to all ones and each byte is fed least significant bit first. The result is inverted, and its 4 bytes follow the last data byte, least significant byte first. out_eop_o is high only on the final trailer byte. For the ASCII bytes "123456789" the trailer is 26h 39h F4h CBh.
- R4: With cfg_crc32_i low, the same rules apply with x^16+x^12+x^5+1 and a 2-byte trailer. For "123456789" the trailer is 6Eh 90h.
- R5: After an end byte is accepted with appending on, in_ready_o is low for exactly as many cycles as there are trailer bytes. Input offered during those cycles is not taken.
- R6: With cfg_append_i low, the packet passes unchanged and out_eop_o marks its last data byte. in_ready_o stays high, and no error is injected. The packet neither consumes nor advances any pending or programmed error request.
- R7: In programmed mode (cfg_err_manual_i low), a pulse on err_arm_i loads cfg_err_count_i and cfg_err_gap_i. The next appended packet is errored. After each errored packet, cfg_err_gap_i clean packets follow. This repeats until cfg_err_count_i packets have been errored.
- R8: In an errored packet, exactly one bit of the trailer value is inverted. Bit k of the value is bit k mod 8 of trailer byte k/8.
- R9: The flipped position is 0 after reset and advances by one after each errored packet. It is kept modulo the current trailer width (16 or 32).
- R10: In manual mode, a request pulse outside a packet marks the next appended packet as errored. Any number of such pulses before that packet yields one errored packet only.
- R11: In manual mode, a request pulse during a packet's data bytes errors that same packet.
- R12: A packet of one byte, with start and end flags on the same byte, gets a correct trailer.
- R13: The mode bit selects the source. Request pulses have no effect in programmed mode, and a loaded programme has no effect in manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can take an input byte |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | First byte of packet |
| in_eop_i | input | 1 | Last byte of packet |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | First output byte of packet |
| out_eop_o | output | 1 | Last output byte of packet |
| cfg_crc32_i | input | 1 | 1: 32-bit check, 0: 16-bit check |
| cfg_append_i | input | 1 | Append trailer |
| cfg_err_manual_i | input | 1 | 1: manual requests, 0: programmed errors |
| cfg_err_count_i | input | CNT_W | Number of errored packets to inject |
| cfg_err_gap_i | input | CNT_W | Clean packets between errored ones |
| err_arm_i | input | 1 | Load programmed count and gap |
| err_req_i | input | 1 | Manual error request pulse |

## Verification
The check value is first compared with the known trailer for "123456789" in both widths, which separates polynomial, bit order, preset and inversion faults. The bench then sends packets of 1, 5 and 64 bytes of varying content, with the trailer computed by a serial model, so that the data-dependent path and the single-byte start/end case are covered. Error patterns use a count and gap of 3 and 1, then a long run at 16 bits that wraps the flipped position. Manual requests are sent twice while idle and once mid-packet, and a request is also sent in programmed mode. Together these separate a missed pending request from a duplicated one, a request that lands in the wrong packet, and a request that crosses between modes. A packet with appending off, sent between arm and the next packet, shows whether the programme is consumed by a packet that carries no trailer.

// File: rtl/fcs_gen_pkg.sv
package fcs_gen_pkg;
  // Reflected polynomial constants for LSB-first processing
  localparam logic [15:0] POLY16_R = 16'h8408;
  localparam logic [31:0] POLY32_R = 32'hEDB8_8320;
  localparam int          BYTE_W   = 8;

  typedef enum logic {ST_DATA, ST_FCS} fcs_st_e;
endpackage

// File: rtl/fcs_gen_crc.sv
module fcs_gen_crc #(
  parameter int            W    = 32,
  parameter logic [W-1:0]  POLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         init_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_next_o
);
  logic [W-1:0] crc_q;

  always_comb begin
    crc_next_o = init_i ? '1 : crc_q;
    for (int i = 0; i < 8; i++) begin
      if (crc_next_o[0] ^ data_i[i]) crc_next_o = (crc_next_o >> 1) ^ POLY;
      else                            crc_next_o = crc_next_o >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '1;
    else if (en_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/fcs_gen_err.sv
module fcs_gen_err #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_acc_i,
  input  logic             eop_acc_i,
  input  logic             append_i,
  input  logic             src_man_i,
  input  logic             crc32_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic             req_i,
  output logic             err_hit_o,
  output logic [4:0]       pos_o
);
  logic [CNT_W-1:0] remain_q, gap_q;
  logic             pend_q, err_q, in_pkt_q;
  logic [4:0]       pos_q, mask;
  logic             reg_hit, sop_dec, cur;

  assign mask    = crc32_i ? 5'd31 : 5'd15;
  assign pos_o   = pos_q & mask;
  assign reg_hit = !src_man_i && (remain_q != '0) && (gap_q == '0);
  assign sop_dec = src_man_i ? (pend_q || req_i) : reg_hit;
  assign cur     = sop_acc_i ? sop_dec : err_q;
  // only meaningful in the cycle an end byte is accepted
  assign err_hit_o = append_i && (cur || (src_man_i && req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      gap_q    <= '0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      in_pkt_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      if (arm_i) begin
        remain_q <= count_i;
        gap_q    <= '0;
      end else if (sop_acc_i && append_i && !src_man_i && remain_q != '0) begin
        if (gap_q == '0) begin
          remain_q <= remain_q - 1'b1;
          gap_q    <= gap_i;
        end else begin
          gap_q <= gap_q - 1'b1;
        end
      end

      if (sop_acc_i)                          err_q <= append_i && sop_dec;
      else if (in_pkt_q && src_man_i && req_i) err_q <= 1'b1;

      if (src_man_i && req_i && !in_pkt_q && !sop_acc_i) pend_q <= 1'b1;
      else if (sop_acc_i && append_i && src_man_i)       pend_q <= 1'b0;

      if (sop_acc_i && !eop_acc_i) in_pkt_q <= 1'b1;
      else if (eop_acc_i)          in_pkt_q <= 1'b0;

      if (eop_acc_i && err_hit_o) pos_q <= (pos_o + 5'd1) & mask;
    end
  end

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eop_acc_i && err_hit_o) |=> $stable(pos_q)); // R9
  AST_REMAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (remain_q == $past(remain_q) || remain_q == $past(remain_q) - 1'b1)); // R7
endmodule

// File: rtl/fcs_gen.sv
module fcs_gen
  import fcs_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  input  logic             cfg_crc32_i,
  input  logic             cfg_append_i,
  input  logic             cfg_err_manual_i,
  input  logic [CNT_W-1:0] cfg_err_count_i,
  input  logic [CNT_W-1:0] cfg_err_gap_i,
  input  logic             err_arm_i,
  input  logic             err_req_i
);
  fcs_st_e     st_q;
  logic        acc;
  logic [15:0] crc16_next;
  logic [31:0] crc32_next, fcs_val, err_mask, fcs_sh_q;
  logic [1:0]  idx_q, idx_last;
  logic        err_hit;
  logic [4:0]  err_pos;

  assign in_ready_o = (st_q == ST_DATA);
  assign acc        = in_valid_i && in_ready_o;
  assign idx_last   = cfg_crc32_i ? 2'd3 : 2'd1;

  fcs_gen_crc #(.W(16), .POLY(POLY16_R)) i_crc16 (
    .clk_i, .rst_ni, .en_i(acc), .init_i(in_sop_i), .data_i(in_data_i),
    .crc_next_o(crc16_next)
  );
  fcs_gen_crc #(.W(32), .POLY(POLY32_R)) i_crc32 (
    .clk_i, .rst_ni, .en_i(acc), .init_i(in_sop_i), .data_i(in_data_i),
    .crc_next_o(crc32_next)
  );

  fcs_gen_err #(.CNT_W(CNT_W)) i_err (
    .clk_i, .rst_ni,
    .sop_acc_i(acc && in_sop_i), .eop_acc_i(acc && in_eop_i),
    .append_i(cfg_append_i), .src_man_i(cfg_err_manual_i), .crc32_i(cfg_crc32_i),
    .arm_i(err_arm_i), .count_i(cfg_err_count_i), .gap_i(cfg_err_gap_i),
    .req_i(err_req_i), .err_hit_o(err_hit), .pos_o(err_pos)
  );

  assign fcs_val  = cfg_crc32_i ? ~crc32_next : {16'h0000, ~crc16_next};
  assign err_mask = err_hit ? (32'd1 << err_pos) : 32'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_DATA;
      fcs_sh_q    <= '0;
      idx_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      case (st_q)
        ST_DATA: if (acc) begin
          out_valid_o <= 1'b1;
          out_data_o  <= in_data_i;
          out_sop_o   <= in_sop_i;
          out_eop_o   <= in_eop_i && !cfg_append_i;
          if (in_eop_i && cfg_append_i) begin
            st_q     <= ST_FCS;
            idx_q    <= '0;
            fcs_sh_q <= fcs_val ^ err_mask;
          end
        end
        ST_FCS: begin
          out_valid_o <= 1'b1;
          out_data_o  <= fcs_sh_q[7:0];
          fcs_sh_q    <= fcs_sh_q >> 8;
          idx_q       <= idx_q + 2'd1;
          if (idx_q == idx_last) begin
            out_eop_o <= 1'b1;
            st_q      <= ST_DATA;
          end
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

  AST_ACC_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o && out_data_o == $past(in_data_i) && out_sop_o == $past(in_sop_i)); // R2
  AST_EOP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> out_valid_o); // R3
  AST_STALL_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_eop_i && cfg_append_i |=> !in_ready_o && !out_eop_o); // R5
  AST_NOAPP_NOSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_eop_i && !cfg_append_i |=> in_ready_o && out_eop_o); // R6
endmodule

// File: tb/test_fcs_gen.sv
module test_fcs_gen;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;
  logic crc32 = 1, append = 1, man = 0, arm = 0, req = 0;
  logic [CNT_W-1:0] cnt = '0, gap = '0;

  int checks = 0, fails = 0, cycles = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pkt_q[$];
  int         exp_pos = 0;

  always #2 clk = ~clk;

  fcs_gen #(.CNT_W(CNT_W)) i_fcs_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .cfg_crc32_i(crc32), .cfg_append_i(append), .cfg_err_manual_i(man),
    .cfg_err_count_i(cnt), .cfg_err_gap_i(gap), .err_arm_i(arm), .err_req_i(req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cycles++;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected output", {22'd0, out_sop, out_eop, out_data}, 0);
      else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_sop, out_eop, out_data} == e, t, {22'd0, out_sop, out_eop, out_data}, {22'd0, e});
      end
    end
  end

  function automatic logic [31:0] model_fcs(bit w32);
    logic [31:0] r, p;
    bit fb;
    r = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p = w32 ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (pkt_q[i])
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ pkt_q[i][b];
        r  = r >> 1;
        if (fb) r = r ^ p;
      end
    return w32 ? ~r : {16'h0, ~r[15:0]};
  endfunction

  task automatic fill(input int len, input int seed);
    pkt_q.delete();
    for (int i = 0; i < len; i++) pkt_q.push_back(8'((seed + i * 37 + (i >> 3)) & 8'hFF));
  endtask

  task automatic send_pkt(input string tag, input bit err_exp, input int req_at,
                          input bit use_ovr, input logic [31:0] ovr);
    logic [31:0] f;
    int nf, n, mask;
    n    = pkt_q.size();
    nf   = crc32 ? 4 : 2;
    mask = crc32 ? 31 : 15;
    f    = use_ovr ? ovr : model_fcs(crc32);
    if (append && err_exp) begin
      f[exp_pos & mask] = ~f[exp_pos & mask];
      exp_pos = (exp_pos + 1) & mask;
    end
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({i == 0, (i == n - 1) && !append, pkt_q[i]});
      tag_q.push_back(tag);
    end
    if (append)
      for (int k = 0; k < nf; k++) begin
        exp_q.push_back({1'b0, k == nf - 1, f[k*8 +: 8]});
        tag_q.push_back(tag);
      end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = pkt_q[i];
      in_sop = (i == 0); in_eop = (i == n - 1);
      req = (i == req_at);
      @(posedge clk);
    end
    @(negedge clk);
    req = 0; in_sop = 0; in_eop = 0;
    if (append) begin
      in_data = 8'hA5; // offered while stalled, must not be taken
      for (int k = 0; k < nf; k++) begin
        chk(!in_ready, "R5 ready low during trailer", in_ready, 0);
        @(negedge clk);
      end
      chk(in_ready, "R5 ready back after trailer", in_ready, 1);
    end else begin
      chk(in_ready, "R6 no stall without append", in_ready, 1);
    end
    in_valid = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
  endtask

  task automatic do_arm(input int c, input int g);
    @(negedge clk); cnt = CNT_W'(c); gap = CNT_W'(g); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    #3;
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready, "R1 in_ready in reset", in_ready, 1);
    #10 rst_n = 1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 idle after reset", {out_valid, in_ready}, 2'b01);

    // R3 known vector, 32-bit
    pkt_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_pkt("R3 crc32 known vector", 0, -1, 1, 32'hCBF4_3926);
    // R4 known vector, 16-bit
    crc32 = 0;
    pkt_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_pkt("R4 crc16 known vector", 0, -1, 1, 32'h0000_906E);
    fill(64, 3);  send_pkt("R4 crc16 64 bytes", 0, -1, 0, 0);
    crc32 = 1;
    fill(1, 200); send_pkt("R12 single byte crc32", 0, -1, 0, 0);
    fill(5, 91);  send_pkt("R2 five bytes crc32", 0, -1, 0, 0);
    fill(64, 17); send_pkt("R3 64 bytes crc32", 0, -1, 0, 0);

    // R13 request in programmed mode ignored
    pulse_req();
    fill(6, 5);   send_pkt("R13 request ignored in programmed mode", 0, 2, 0, 0);

    // R6 append off keeps programme untouched
    do_arm(1, 0);
    append = 0;
    fill(7, 44);  send_pkt("R6 pass through without trailer", 0, -1, 0, 0);
    append = 1;
    fill(7, 45);  send_pkt("R7 R8 first armed packet errored bit0", 1, -1, 0, 0);
    fill(4, 46);  send_pkt("R7 programme exhausted", 0, -1, 0, 0);

    // R7 count 3 gap 1
    do_arm(3, 1);
    for (int p = 0; p < 7; p++) begin
      fill(3 + p, 60 + p);
      send_pkt("R7 count3 gap1 pattern", (p == 0) || (p == 2) || (p == 4), -1, 0, 0);
    end

    // R10 manual: two idle pulses give one errored packet
    man = 1;
    do_arm(5, 0); // R13 programme ignored in manual mode
    pulse_req();
    pulse_req();
    fill(8, 120); send_pkt("R10 pending request errors next packet", 1, -1, 0, 0);
    fill(8, 121); send_pkt("R10 only one pending request kept", 0, -1, 0, 0);
    fill(9, 122); send_pkt("R11 mid-packet request", 1, 4, 0, 0);
    fill(9, 123); send_pkt("R13 manual mode ignores programme", 0, -1, 0, 0);

    // R9 wrap at 16-bit width
    man = 0;
    crc32 = 0;
    do_arm(14, 0);
    for (int p = 0; p < 14; p++) begin
      fill(2 + (p % 3), 150 + p);
      send_pkt("R9 position advance and wrap", 1, -1, 0, 0);
    end
    fill(5, 99);  send_pkt("R9 after wrap clean", 0, -1, 0, 0);
    crc32 = 1;
    do_arm(1, 0);
    fill(5, 98);  send_pkt("R8 R9 errored after width change", 1, -1, 0, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule